// File: doc/BRIEF.md
# Programmable Rate Divider

The rate divider turns a time-base enable strobe into three timing outputs: a one-cycle calendar tick once per second, a selectable square wave for an output pin, and a periodic event strobe. Everything runs in the system clock domain. The time base arrives as `base_en`, a one-cycle strobe at twice the 32.768 kHz crystal rate (65.536 kHz). A free-running 16-bit divider counts these strobes. Bit 0 of the divider is therefore the 32.768 kHz phase, and bit k toggles at 32768 / 2^k Hz.

A 4-bit rate code picks one divider tap. That tap drives both the square wave and the periodic strobe. A 3-bit oscillator-control field decides whether the divider runs. Under one control value, and only that value, a 32 kHz enable bit can be set. When that bit is set, the pin carries the raw 32.768 kHz phase in place of the selected tap. The periodic strobe does not change and still follows the rate code.

Top module: `rate_divider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `sq_out`, `per_pulse`, `sec_tick` and `fast_en` are 0. The divider starts from 0.
- R2: Rate code 0 keeps `per_pulse` at 0. With `fast_en` clear, rate code 0 also keeps `sq_out` at 0.
- R3: Rate codes 1 and 2 give the same rates as codes 8 and 9: 256 Hz and 128 Hz on the pin, and a periodic strobe every 256 and 512 base strobes.
- R4: A rate code s from 3 to 15 puts a square wave of 32768 / 2^(s-1) Hz on the pin, which is divider bit s-1. It also raises `per_pulse` once every 2^s base strobes. Code 3 gives 8.192 kHz and code 15 gives 2 Hz.
- R5: The divider runs only when `osc_ctl` is 3'b010 or 3'b011. Any other value, including 3'b11x, holds the divider at 0. With the divider held, the tap, `per_pulse` and `sec_tick` stay 0.
- R6: When `sq_en` is 0, `sq_out` is 0.
- R7: Raw mode applies when `osc_ctl` = 3'b011, `fast_en` = 1 and `sq_en` = 1. In raw mode `sq_out` is divider bit 0, which toggles on every base strobe. `per_pulse` keeps following the rate code.
- R8: `fast_en` loads `fast_wdata` on a `fast_wr` cycle only while `osc_ctl` = 3'b011. In any cycle where `osc_ctl` has another value, `fast_en` clears on the next edge.
- R9: `sec_tick` is high for one cycle on the base strobe that wraps the divider from all ones to 0. That is once per 65536 base strobes, or once per second.
- R10: `per_pulse` is high for exactly one cycle after each rising edge of the selected tap. In the cycle in which the rate code changes, no pulse is produced.
- R11: The divider advances by one only on cycles with `base_en` high. On other cycles it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_en | input | 1 | Time-base strobe at 65.536 kHz |
| rate_sel | input | 4 | Rate code |
| osc_ctl | input | 3 | Oscillator and divider control field |
| sq_en | input | 1 | Square-wave pin enable |
| fast_wr | input | 1 | Write strobe for the 32 kHz enable bit |
| fast_wdata | input | 1 | Value written to the 32 kHz enable bit |
| fast_en | output | 1 | Current 32 kHz enable bit |
| sq_out | output | 1 | Square-wave pin |
| per_pulse | output | 1 | Periodic event strobe |
| sec_tick | output | 1 | One-second calendar tick |

## Verification
The assertions assume that the control inputs change only between clock edges and are treated as register bits. They also assume that `base_en` never arrives so often that the divider could wrap two cycles in a row.

The stimulus changes inputs a fixed delay after each rising edge. It drives `base_en` either on every cycle or on a random subset of cycles. It reaches every oscillator-control class, the aliased rate codes, the slowest rate code and the rate changes made while the divider runs.

// File: rtl/rdiv_pkg.sv
// Shared types and decode helpers for the rate divider.
// Assumes a 4-bit rate code and a 3-bit oscillator control field.
package rdiv_pkg;

    localparam int SEL_W      = 4;
    localparam int CTL_W      = 3;
    // Codes below this value alias onto slower codes.
    localparam int ALIAS_LIM  = 3;
    // Offset that maps an aliased code onto its twin.
    localparam int ALIAS_SHIFT = 7;

    typedef enum logic [1:0] {
        OSC_STOP    = 2'd0,
        OSC_HOLD    = 2'd1,
        OSC_RUN     = 2'd2,
        OSC_RUN_EXT = 2'd3
    } osc_mode_e;

    // Classify the oscillator control field.
    function automatic osc_mode_e decode_osc(input logic [CTL_W-1:0] c);
        case (c)
            3'b010:         return OSC_RUN;
            3'b011:         return OSC_RUN_EXT;
            3'b110, 3'b111: return OSC_HOLD;
            default:        return OSC_STOP;
        endcase
    endfunction

    // Divider bit index selected by a nonzero rate code.
    function automatic int unsigned tap_index(input logic [SEL_W-1:0] s);
        int unsigned code;
        code = (int'(s) < ALIAS_LIM) ? int'(s) + ALIAS_SHIFT : int'(s);
        return code - 1;
    endfunction

endpackage

// File: rtl/rdiv_counter.sv
// Free-running time-base divider.
// Counts base strobes while the oscillator mode allows it and is held at 0 otherwise.
// Raises a one-cycle tick on the strobe that wraps the counter.
// Assumes base_en is a single-cycle strobe in the clk domain.
module rdiv_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             sec_tick
);

    // Advance on each base strobe; clear while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (base_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Wrap detection for the calendar tick.
    assign sec_tick = run && base_en && (&cnt);

    a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !base_en) |=> $stable(cnt));
    a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

endmodule

// File: rtl/rdiv_tap.sv
// Tap selector and edge strobe.
// Picks the divider bit named by the rate code and pulses for one cycle on each rising edge of that bit.
// A change of rate code re-arms the edge detector without emitting a pulse.
// Assumes the counter is held at 0 whenever run is low.
module rdiv_tap
    import rdiv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             run,
    output logic             tap,
    output logic             per_pulse
);

    localparam int IDX_W = $clog2(CNT_W);

    logic [IDX_W-1:0] idx;
    logic             tap_q;
    logic [SEL_W-1:0] sel_q;

    // Resolve the rate code to a divider bit.
    assign idx = IDX_W'(tap_index(rate_sel));
    assign tap = run && (rate_sel != '0) && cnt[idx];

    // Remember the previous tap level and rate code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= 1'b0;
            sel_q <= '0;
        end else begin
            tap_q <= tap;
            sel_q <= rate_sel;
        end
    end

    // Rising edge of the tap; suppressed in the cycle the code changes.
    assign per_pulse = tap && !tap_q && (rate_sel == sel_q);

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |=> !per_pulse);

endmodule

// File: rtl/rdiv_fast_ctl.sv
// Holder for the 32 kHz enable bit.
// The bit is writable only in the extended run mode and clears in any other mode.
module rdiv_fast_ctl
    import rdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  osc_mode_e mode,
    input  logic      fast_wr,
    input  logic      fast_wdata,
    output logic      fast_q
);

    // Load on write in the extended mode; clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != OSC_RUN_EXT) begin
            fast_q <= 1'b0;
        end else if (fast_wr) begin
            fast_q <= fast_wdata;
        end
    end

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != OSC_RUN_EXT) |=> !fast_q);

endmodule

// File: rtl/rate_divider.sv
// Programmable rate divider: top level.
// Decodes the oscillator control field, runs the divider, selects the shared tap and muxes the pin between the tap and the raw 32.768 kHz phase.
// Assumes base_en arrives at twice the 32.768 kHz rate.
module rate_divider
    import rdiv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  logic [3:0]       rate_sel,
    input  logic [2:0]       osc_ctl,
    input  logic             sq_en,
    input  logic             fast_wr,
    input  logic             fast_wdata,
    output logic             fast_en,
    output logic             sq_out,
    output logic             per_pulse,
    output logic             sec_tick
);

    osc_mode_e        mode;
    logic             run;
    logic             raw;
    logic             tap;
    logic [CNT_W-1:0] cnt;

    // Mode decode shared by the sub-blocks.
    assign mode = decode_osc(osc_ctl);
    assign run  = (mode == OSC_RUN) || (mode == OSC_RUN_EXT);

    rdiv_counter #(.CNT_W(CNT_W)) counter_i (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .run(run),
        .cnt(cnt), .sec_tick(sec_tick)
    );

    rdiv_tap #(.CNT_W(CNT_W)) tap_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .rate_sel(rate_sel), .run(run),
        .tap(tap), .per_pulse(per_pulse)
    );

    rdiv_fast_ctl fast_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fast_wr(fast_wr),
        .fast_wdata(fast_wdata), .fast_q(fast_en)
    );

    // Pin source: raw base phase in the extended mode, otherwise the tap.
    assign raw    = (mode == OSC_RUN_EXT) && fast_en;
    assign sq_out = sq_en && (raw ? cnt[0] : tap);

    a_r6_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |-> !sq_out);

endmodule

// File: tb/rate_divider_tb_top.sv
module rate_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_en = 1'b1;
    logic [3:0] rate_sel = 4'd3;
    logic [2:0] osc_ctl = 3'b010;
    logic       sq_en = 1'b1;
    logic       fast_wr = 1'b0;
    logic       fast_wdata = 1'b0;
    logic       fast_en, sq_out, per_pulse, sec_tick;

    int errors = 0;
    int checks = 0;
    bit gap_mode = 0;
    bit win_on = 0;
    int n_pulse = 0, n_sq = 0, n_tick = 0;
    int cyc = 0;

    // Reference model state
    int m_cnt = 0, m_fast = 0, m_tapq = 0, m_selq = 0;

    always #2.5 clk = ~clk;

    rate_divider dut_i (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .rate_sel(rate_sel),
        .osc_ctl(osc_ctl), .sq_en(sq_en), .fast_wr(fast_wr), .fast_wdata(fast_wdata),
        .fast_en(fast_en), .sq_out(sq_out), .per_pulse(per_pulse), .sec_tick(sec_tick)
    );

    function automatic int m_run();
        return (osc_ctl == 3'b010 || osc_ctl == 3'b011) ? 1 : 0;
    endfunction

    function automatic int m_tap();
        int idx;
        if (rate_sel == 0 || m_run() == 0) return 0;
        idx = (rate_sel < 3) ? int'(rate_sel) + 6 : int'(rate_sel) - 1;
        return (m_cnt >> idx) & 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Model update at each edge from stable inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_fast = 0; m_tapq = 0; m_selq = 0;
        end else begin
            m_tapq = m_tap();
            m_selq = int'(rate_sel);
            if (osc_ctl != 3'b011) m_fast = 0;
            else if (fast_wr) m_fast = int'(fast_wdata);
            if (m_run() == 0) m_cnt = 0;
            else if (base_en) m_cnt = (m_cnt + 1) % 65536;
        end
        if (cyc > 200000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=200000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int e_sq, e_pulse, e_tick;
            int raw;
            raw = (osc_ctl == 3'b011 && m_fast == 1) ? 1 : 0;
            e_sq = sq_en ? (raw ? (m_cnt & 1) : m_tap()) : 0;
            e_pulse = (m_tap() == 1 && m_tapq == 0 && int'(rate_sel) == m_selq) ? 1 : 0;
            e_tick = (m_run() == 1 && base_en && m_cnt == 65535) ? 1 : 0;
            check("R4 sq_out", int'(sq_out), e_sq);
            check("R10 per_pulse", int'(per_pulse), e_pulse);
            check("R9 sec_tick", int'(sec_tick), e_tick);
            check("R8 fast_en", int'(fast_en), m_fast);
            if (win_on) begin
                n_pulse += int'(per_pulse);
                n_sq    += int'(sq_out);
                n_tick  += int'(sec_tick);
            end
        end
    end

    // Time-base strobe: every cycle or a random subset.
    always @(posedge clk) begin
        #1 base_en <= gap_mode ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic window(input int w);
        n_pulse = 0; n_sq = 0; n_tick = 0;
        win_on = 1;
        tick(w);
        win_on = 0;
    endtask

    initial begin
        // R1: reset state
        tick(3);
        check("R1 sq_out in reset", int'(sq_out), 0);
        check("R1 per_pulse in reset", int'(per_pulse), 0);
        check("R1 fast_en in reset", int'(fast_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sq_out after reset", int'(sq_out), 0);
        check("R1 sec_tick after reset", int'(sec_tick), 0);
        tick(1);

        // R4: code 3, period 8 strobes
        tick(40);
        window(256);
        check("R4 code3 pulses", n_pulse, 32);
        check("R4 code3 sq highs", n_sq, 128);

        // R3: aliases
        rate_sel = 4'd1; tick(600); window(1024);
        check("R3 code1 pulses", n_pulse, 4);
        rate_sel = 4'd8; tick(600); window(1024);
        check("R3 code8 pulses", n_pulse, 4);
        rate_sel = 4'd2; tick(1100); window(2048);
        check("R3 code2 pulses", n_pulse, 4);
        rate_sel = 4'd9; tick(1100); window(2048);
        check("R3 code9 pulses", n_pulse, 4);

        // R2: code 0
        rate_sel = 4'd0; window(500);
        check("R2 code0 pulses", n_pulse, 0);
        check("R2 code0 sq highs", n_sq, 0);

        // R6: pin disabled, strobe unaffected
        rate_sel = 4'd3; sq_en = 1'b0; tick(40); window(256);
        check("R6 sq highs while disabled", n_sq, 0);
        check("R6 pulses while pin disabled", n_pulse, 32);
        sq_en = 1'b1;

        // R8: write refused outside extended mode
        fast_wr = 1'b1; fast_wdata = 1'b1; tick(1); fast_wr = 1'b0;
        @(negedge clk);
        check("R8 write refused under 010", int'(fast_en), 0);
        tick(1);
        osc_ctl = 3'b011; tick(2);
        fast_wr = 1'b1; fast_wdata = 1'b1; tick(1); fast_wr = 1'b0;
        @(negedge clk);
        check("R8 write accepted under 011", int'(fast_en), 1);
        tick(1);

        // R7: raw phase on the pin, strobe follows code 5
        rate_sel = 4'd5; tick(80); window(256);
        check("R7 raw sq highs", n_sq, 128);
        check("R7 pulses under raw", n_pulse, 8);

        // R8: leaving extended mode clears the bit
        osc_ctl = 3'b010; tick(1);
        @(negedge clk);
        check("R8 cleared after 010", int'(fast_en), 0);
        tick(1);

        // R5: held modes
        osc_ctl = 3'b110; window(300);
        check("R5 hold 110 pulses", n_pulse + n_sq + n_tick, 0);
        osc_ctl = 3'b000; window(300);
        check("R5 stop 000 pulses", n_pulse + n_sq + n_tick, 0);
        osc_ctl = 3'b101; fast_wr = 1'b1; window(50); fast_wr = 1'b0;
        check("R5 stop 101 and R8 fast_en", int'(fast_en) + n_pulse, 0);

        // R11 and R10: sparse strobes and code changes while running
        osc_ctl = 3'b010; gap_mode = 1;
        for (int k = 0; k < 12; k++) begin
            rate_sel = 4'(k + 3);
            tick(300);
        end
        rate_sel = 4'd4; tick(7); rate_sel = 4'd3; tick(5); rate_sel = 4'd1; tick(400);
        gap_mode = 0;

        // R9: one-second tick and slowest code from a fresh start
        osc_ctl = 3'b000; rate_sel = 4'd15; tick(2);
        osc_ctl = 3'b010;
        window(65536);
        check("R9 ticks per 65536 strobes", n_tick, 1);
        check("R4 code15 pulses", n_pulse, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule